// File: doc/BRIEF.md
# Smart Card Session Sequencer

This block runs the power-up and power-down order for one contact smart card. A host drives an active-low session command and a reset request. The block answers by switching on card supply, I/O reception, the card clock and the card reset in a fixed order. It takes them down again in the reverse order when the host ends the session, when a supervisor reports a fault, or when the card is pulled out.

All waits are counted in strobes of a slow time base, nominally 1.5 MHz, on `tick`. The reset hold-off is counted in card clock strobes on `cclk_en`. Each wait is a parameter.

A single active-low interrupt serves two purposes. Outside a session it shows whether a card is in the slot. Inside a session it shows that the session was ended by a fault or by card removal.

All pins are plain control and status levels. The block has no streaming interface, so no valid/ready handshake applies.

Top module: `card_seq_top`

## Requirements
- R1: Starting a session is refused until `TICKS_POR` ticks have passed since reset, or since the last cycle in which `flt_vdd` was high.
- R2: A session starts only on a high-to-low transition of `cmd_n`, and only when a card is present and both `flt_temp` and `flt_vdd` are low. The first visible effect is `vcc_en` rising; holding `cmd_n` low does not start a second session.
- R3: After `TICKS_T1` ticks with supply on, `vcc_ok` is sampled. If it is low, `irq_n` goes low and the shutdown order runs, so `vcc_en` falls without I/O, clock or reset ever turning on.
- R4: If `rst_req` was low when the session started, `io_rx_en` rises `TICKS_T1 + TICKS_T2` ticks after `vcc_en` rose. If `rst_req` was high, `io_rx_en` stays low until `rst_req` falls.
- R5: `card_clk_en` rises `TICKS_T3` ticks after `io_rx_en` rose.
- R6: `card_rst` stays low until `RST_CCLK` `cclk_en` strobes have been counted with the clock running. After that it follows `rst_req`, even if `rst_req` went high earlier.
- R7: Shutdown drops outputs in this order: `card_rst` after `TICKS_D1` ticks, then `card_clk_en` after `TICKS_D2` more, then `io_rx_en` after `TICKS_D3` more, then `vcc_en` after `TICKS_D4` more. A host-requested shutdown leaves `irq_n` high.
- R8: While `vcc_en` is low, `irq_n` equals card presence (low = no card). Fault inputs change nothing.
- R9: During a session, any of `flt_oc`, `flt_temp`, `flt_vdd`, `flt_vpc`, `flt_vcc`, or the loss of card presence, drives `irq_n` low on the next clock and starts the shutdown order. `irq_n` stays low until `vcc_en` falls.
- R10: A card counts as present when `pres_hi` is high or `pres_lo_n` is low; either input alone is enough.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle strobe of the slow time base |
| cclk_en | input | 1 | One-cycle strobe per card clock period |
| cmd_n | input | 1 | Session command, active low, edge started |
| rst_req | input | 1 | Host card reset request |
| pres_hi | input | 1 | Presence switch, high = card |
| pres_lo_n | input | 1 | Presence switch, low = card |
| flt_oc | input | 1 | Card over-current fault |
| flt_temp | input | 1 | Over-temperature fault |
| flt_vdd | input | 1 | Logic supply fault |
| flt_vpc | input | 1 | Regulator input supply fault |
| flt_vcc | input | 1 | Card supply fault |
| vcc_ok | input | 1 | Card supply reached its level |
| vcc_en | output | 1 | Card supply enable |
| io_rx_en | output | 1 | I/O reception enable |
| card_clk_en | output | 1 | Card clock running |
| card_rst | output | 1 | Card reset line |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The bench targets these corner cases:
- A session command issued during the start-up hold-off, or right after a logic-supply dip. A design that ignores the hold-off would power the card.
- A fault raised while idle. A leaky design would pull `irq_n` low or start a shutdown.
- The reset request raised long before the card clock count completes. A design with a short or missing count would release `card_rst` early.
- A session started with the reset request already high. A design that ignores this mode would turn on reception after the timer instead of at the request's fall.
- A failed supply check, a fault and a card removal, each in mid-session. Here an event-ordered scoreboard catches any output that changes out of turn, or that changes and was never due to change at all.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PWRUP,
    S_IOWAIT,
    S_CLKWAIT,
    S_RUN,
    S_D_RST,
    S_D_CLK,
    S_D_IO,
    S_D_VCC
  } seq_state_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seq_interval.sv
module seq_interval #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;

  assign hit = tick && (cnt == limit - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (tick)    cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/seq_por_guard.sv
module seq_por_guard #(
  parameter int TICKS_POR = 15000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic flt_vdd,
  output logic ready
);
  localparam int PW = $clog2(TICKS_POR + 1);
  logic [PW-1:0] cnt;

  assign ready = (cnt == PW'(TICKS_POR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (flt_vdd)          cnt <= '0;
    else if (tick && !ready)   cnt <= cnt + PW'(1);
  end
endmodule

// File: rtl/seq_rst_gate.sv
module seq_rst_gate #(
  parameter int RST_CCLK = 42000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic cclk_en,
  output logic open
);
  localparam int CW = $clog2(RST_CCLK + 1);
  logic [CW-1:0] cnt;

  assign open = (cnt == CW'(RST_CCLK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (!run)               cnt <= '0;
    else if (cclk_en && !open)   cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/card_seq_top.sv
module card_seq_top
  import card_seq_pkg::*;
#(
  parameter int TICKS_POR = 15000,
  parameter int TICKS_T1  = 765,
  parameter int TICKS_T2  = 3,
  parameter int TICKS_T3  = 1,
  parameter int RST_CCLK  = 42000,
  parameter int TICKS_D1  = 1,
  parameter int TICKS_D2  = 12,
  parameter int TICKS_D3  = 1,
  parameter int TICKS_D4  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cclk_en,
  input  logic cmd_n,
  input  logic rst_req,
  input  logic pres_hi,
  input  logic pres_lo_n,
  input  logic flt_oc,
  input  logic flt_temp,
  input  logic flt_vdd,
  input  logic flt_vpc,
  input  logic flt_vcc,
  input  logic vcc_ok,
  output logic vcc_en,
  output logic io_rx_en,
  output logic card_clk_en,
  output logic card_rst,
  output logic irq_n
);
  localparam int LIM_MAX = max_of(max_of(max_of(TICKS_T1, TICKS_T2), max_of(TICKS_T3, TICKS_D1)),
                                  max_of(max_of(TICKS_D2, TICKS_D3), TICKS_D4));
  localparam int IW = $clog2(LIM_MAX + 1);

  seq_state_t state, state_nxt;
  logic cmd_q, rst_hi_q, flt_lat;
  logic vcc_q, io_q, clk_q, rst_q;
  logic present, any_flt, in_sess, kill_flt, kill, cmd_fall;
  logic por_ok, gate_open, step, io_go, restart;
  logic [IW-1:0] limit;

  assign present  = pres_hi | ~pres_lo_n;
  assign any_flt  = flt_oc | flt_temp | flt_vdd | flt_vpc | flt_vcc;
  assign cmd_fall = cmd_q & ~cmd_n;
  assign in_sess  = (state == S_PWRUP) || (state == S_IOWAIT) ||
                    (state == S_CLKWAIT) || (state == S_RUN);
  assign kill_flt = in_sess & (any_flt | ~present);
  assign kill     = kill_flt | (in_sess & cmd_n);
  assign io_go    = rst_hi_q ? ~rst_req : step;
  assign restart  = (state_nxt != state);

  seq_por_guard #(.TICKS_POR(TICKS_POR)) u_por (
    .clk(clk), .rst_n(rst_n), .tick(tick), .flt_vdd(flt_vdd), .ready(por_ok)
  );

  seq_rst_gate #(.RST_CCLK(RST_CCLK)) u_gate (
    .clk(clk), .rst_n(rst_n), .run(clk_q && (state == S_RUN)),
    .cclk_en(cclk_en), .open(gate_open)
  );

  seq_interval #(.W(IW)) u_ivl (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
    .limit(limit), .hit(step)
  );

  always_comb begin
    case (state)
      S_PWRUP:   limit = IW'(TICKS_T1);
      S_IOWAIT:  limit = IW'(TICKS_T2);
      S_CLKWAIT: limit = IW'(TICKS_T3);
      S_D_RST:   limit = IW'(TICKS_D1);
      S_D_CLK:   limit = IW'(TICKS_D2);
      S_D_IO:    limit = IW'(TICKS_D3);
      S_D_VCC:   limit = IW'(TICKS_D4);
      default:   limit = IW'(1);
    endcase
  end

  always_comb begin
    state_nxt = state;
    if (kill) state_nxt = S_D_RST;
    else begin
      case (state)
        S_IDLE:    if (cmd_fall && present && !flt_temp && !flt_vdd && por_ok)
                     state_nxt = S_PWRUP;
        S_PWRUP:   if (step) state_nxt = vcc_ok ? S_IOWAIT : S_D_RST;
        S_IOWAIT:  if (io_go) state_nxt = S_CLKWAIT;
        S_CLKWAIT: if (step) state_nxt = S_RUN;
        S_D_RST:   if (step) state_nxt = S_D_CLK;
        S_D_CLK:   if (step) state_nxt = S_D_IO;
        S_D_IO:    if (step) state_nxt = S_D_VCC;
        S_D_VCC:   if (step) state_nxt = S_IDLE;
        default:   state_nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cmd_q    <= 1'b1;
      rst_hi_q <= 1'b0;
      flt_lat  <= 1'b0;
      vcc_q    <= 1'b0;
      io_q     <= 1'b0;
      clk_q    <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      state <= state_nxt;
      cmd_q <= cmd_n;
      if (state == S_IDLE && state_nxt == S_PWRUP) begin
        vcc_q    <= 1'b1;
        rst_hi_q <= rst_req;
      end
      if (kill_flt || (state == S_PWRUP && step && !vcc_ok)) flt_lat <= 1'b1;
      if (state == S_IOWAIT && state_nxt == S_CLKWAIT) io_q <= 1'b1;
      if (state == S_CLKWAIT && state_nxt == S_RUN) clk_q <= 1'b1;
      if (state == S_RUN) rst_q <= gate_open & rst_req;
      else if (state != S_D_RST || step) rst_q <= 1'b0;
      if (state == S_D_CLK && step) clk_q <= 1'b0;
      if (state == S_D_IO && step) io_q <= 1'b0;
      if (state == S_D_VCC && step) begin
        vcc_q   <= 1'b0;
        flt_lat <= 1'b0;
      end
    end
  end

  assign vcc_en      = vcc_q;
  assign io_rx_en    = io_q;
  assign card_clk_en = clk_q;
  assign card_rst    = rst_q;
  assign irq_n       = (state == S_IDLE) ? present : ~flt_lat;
endmodule

// File: rtl/card_seq_chk.sv
module card_seq_chk #(
  parameter int RST_CCLK = 42000
) (
  input logic clk,
  input logic rst_n,
  input logic cclk_en,
  input logic pres_hi,
  input logic pres_lo_n,
  input logic flt_temp,
  input logic flt_vdd,
  input logic vcc_en,
  input logic io_rx_en,
  input logic card_clk_en,
  input logic card_rst,
  input logic irq_n
);
  localparam int CW = $clog2(RST_CCLK + 1);
  logic [CW-1:0] seen;
  logic present;

  assign present = pres_hi | ~pres_lo_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   seen <= '0;
    else if (!card_clk_en)                        seen <= '0;
    else if (cclk_en && seen != CW'(RST_CCLK))    seen <= seen + CW'(1);
  end

  p_start_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vcc_en) |-> $past(present && !flt_temp && !flt_vdd));

  p_io_needs_vcc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    io_rx_en |-> vcc_en);

  p_clk_needs_io_r5: assert property (@(posedge clk) disable iff (!rst_n)
    card_clk_en |-> io_rx_en);

  p_rst_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> (card_clk_en && seen == CW'(RST_CCLK)));

  p_rst_before_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_clk_en) |-> !card_rst);

  p_idle_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_en |-> (irq_n == present));
endmodule

bind card_seq_top card_seq_chk #(.RST_CCLK(RST_CCLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .cclk_en(cclk_en), .pres_hi(pres_hi),
  .pres_lo_n(pres_lo_n), .flt_temp(flt_temp), .flt_vdd(flt_vdd),
  .vcc_en(vcc_en), .io_rx_en(io_rx_en), .card_clk_en(card_clk_en),
  .card_rst(card_rst), .irq_n(irq_n)
);

// File: tb/card_seq_top_tb.sv
module card_seq_top_tb;
  localparam int P_POR = 4, P_T1 = 5, P_T2 = 3, P_T3 = 1, P_RC = 20;
  localparam int P_D1 = 1, P_D2 = 3, P_D3 = 1, P_D4 = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0, tick = 1'b0, cclk_en = 1'b0;
  logic cmd_n = 1'b1, rst_req = 1'b0, pres_hi = 1'b0, pres_lo_n = 1'b1;
  logic flt_oc = 1'b0, flt_temp = 1'b0, flt_vdd = 1'b0, flt_vpc = 1'b0, flt_vcc = 1'b0;
  logic vcc_ok = 1'b1;
  logic vcc_en, io_rx_en, card_clk_en, card_rst, irq_n;
  logic [4:0] o_vec, prev;
  logic [4:0] exp_q[$];
  string tag_q[$];
  int total = 0, bad = 0, t12cnt = 0, t3cnt = 0;
  bit started = 0, done = 0;

  always #2 clk = ~clk;

  card_seq_top #(.TICKS_POR(P_POR), .TICKS_T1(P_T1), .TICKS_T2(P_T2), .TICKS_T3(P_T3),
    .RST_CCLK(P_RC), .TICKS_D1(P_D1), .TICKS_D2(P_D2), .TICKS_D3(P_D3), .TICKS_D4(P_D4)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cclk_en(cclk_en), .cmd_n(cmd_n),
    .rst_req(rst_req), .pres_hi(pres_hi), .pres_lo_n(pres_lo_n), .flt_oc(flt_oc),
    .flt_temp(flt_temp), .flt_vdd(flt_vdd), .flt_vpc(flt_vpc), .flt_vcc(flt_vcc),
    .vcc_ok(vcc_ok), .vcc_en(vcc_en), .io_rx_en(io_rx_en), .card_clk_en(card_clk_en),
    .card_rst(card_rst), .irq_n(irq_n));

  assign o_vec = {irq_n, vcc_en, io_rx_en, card_clk_en, card_rst};

  int phase = 0;
  always @(negedge clk) begin
    phase <= phase + 1;
    tick <= (phase % 4 == 0);
    cclk_en <= (phase % 2 == 0);
  end

  always @(posedge clk) begin
    if (tick && vcc_en && !io_rx_en) t12cnt <= t12cnt + 1;
    if (tick && io_rx_en && !card_clk_en) t3cnt <= t3cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [4:0] v, input string req);
    exp_q.push_back(v);
    tag_q.push_back(req);
  endtask

  // scoreboard monitor: every output change must match the next expected vector
  always @(negedge clk) begin
    if (started && o_vec != prev) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL unexpected change actual=%b expected=%b", o_vec, prev);
      end else begin
        logic [4:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(o_vec == e, t, int'(o_vec), int'(e));
      end
      prev = o_vec;
    end
  end

  task automatic wait_ticks(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic wait_bit(input int idx, input logic v);
    for (int i = 0; i < 4000 && o_vec[idx] != v; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(o_vec == 5'b00000, "R8 reset", int'(o_vec), 0);
    prev = o_vec;
    started = 1;

    // R10 presence via active-low input; R1 hold-off after reset
    push(5'b10000, "R10");
    pres_lo_n = 1'b0;
    repeat (2) @(negedge clk);
    cmd_n = 1'b0;
    wait_ticks(10);
    chk(vcc_en == 1'b0, "R1 hold-off after reset", vcc_en, 0);
    cmd_n = 1'b1;
    // R1 hold-off after logic supply dip (R8: no irq change)
    wait_ticks(2);
    flt_vdd = 1'b1;
    wait_ticks(2);
    flt_vdd = 1'b0;
    @(negedge clk);
    cmd_n = 1'b0;
    wait_ticks(10);
    chk(vcc_en == 1'b0, "R1 hold-off after vdd dip", vcc_en, 0);
    cmd_n = 1'b1;
    wait_ticks(8);

    // R2 refused with over-temperature, R8 fault ignored when idle
    flt_temp = 1'b1;
    wait_ticks(1);
    cmd_n = 1'b0;
    wait_ticks(10);
    chk(vcc_en == 1'b0, "R2 refused on temp fault", vcc_en, 0);
    chk(irq_n == 1'b1, "R8 idle fault ignored", irq_n, 1);
    cmd_n = 1'b1;
    flt_temp = 1'b0;
    wait_ticks(2);

    // normal session, reset request low at start
    push(5'b11000, "R2 supply on");
    push(5'b11100, "R4 reception on");
    push(5'b11110, "R5 clock on");
    push(5'b11111, "R6 reset follows");
    push(5'b11110, "R7 reset off first");
    push(5'b11100, "R7 clock off second");
    push(5'b11000, "R7 io off third");
    push(5'b10000, "R7 supply off last");
    t12cnt = 0;
    cmd_n = 1'b0;
    wait_bit(2, 1'b1);
    chk(t12cnt == P_T1 + P_T2, "R4 t1+t2 ticks", t12cnt, P_T1 + P_T2);
    t3cnt = 0;
    wait_bit(1, 1'b1);
    chk(t3cnt == P_T3, "R5 t3 ticks", t3cnt, P_T3);
    rst_req = 1'b1;
    repeat (36) @(negedge clk);
    chk(card_rst == 1'b0, "R6 reset held before count", card_rst, 0);
    repeat (8) @(negedge clk);
    chk(card_rst == 1'b1, "R6 reset released after count", card_rst, 1);
    cmd_n = 1'b1;
    wait_bit(3, 1'b0);
    chk(irq_n == 1'b1, "R7 host shutdown keeps irq high", irq_n, 1);
    wait_ticks(2);

    // session with reset request high at start, then over-current fault
    push(5'b11000, "R4 supply on");
    cmd_n = 1'b0;
    wait_ticks(20);
    chk(io_rx_en == 1'b0, "R4 reception waits for request fall", io_rx_en, 0);
    push(5'b11100, "R4 reception on request fall");
    push(5'b11110, "R5 clock on");
    rst_req = 1'b0;
    wait_ticks(4);
    chk(card_clk_en == 1'b1, "R5 clock running", card_clk_en, 1);
    push(5'b01110, "R9 irq on fault");
    push(5'b01100, "R9 clock off");
    push(5'b01000, "R9 io off");
    push(5'b10000, "R9 supply off");
    flt_oc = 1'b1;
    wait_bit(3, 1'b0);
    flt_oc = 1'b0;
    wait_ticks(10);
    chk(vcc_en == 1'b0, "R2 held-low command does not restart", vcc_en, 0);
    cmd_n = 1'b1;
    wait_ticks(2);

    // R3 supply check fails
    vcc_ok = 1'b0;
    push(5'b11000, "R3 supply on");
    push(5'b01000, "R3 irq on bad supply");
    push(5'b10000, "R3 supply off");
    cmd_n = 1'b0;
    wait_ticks(20);
    chk(vcc_en == 1'b0 && irq_n == 1'b1, "R3 ended", int'(o_vec), 5'b10000);
    cmd_n = 1'b1;
    vcc_ok = 1'b1;
    wait_ticks(2);

    // R9 card removal mid-session
    push(5'b11000, "R9 supply on");
    push(5'b11100, "R9 reception on");
    push(5'b11110, "R9 clock on");
    cmd_n = 1'b0;
    wait_bit(1, 1'b1);
    push(5'b01110, "R9 irq on removal");
    push(5'b01100, "R9 clock off");
    push(5'b01000, "R9 io off");
    push(5'b00000, "R9 supply off, no card");
    pres_lo_n = 1'b1;
    wait_bit(3, 1'b0);
    @(negedge clk);
    chk(irq_n == 1'b0, "R9 irq low after removal", irq_n, 0);
    cmd_n = 1'b1;

    // R10 presence via active-high input
    push(5'b10000, "R10 active-high presence");
    pres_hi = 1'b1;
    repeat (2) @(negedge clk);
    chk(irq_n == 1'b1, "R10 irq high", irq_n, 1);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "all expected events seen", exp_q.size(), 0);
    finish_run();
  end
endmodule